// File: doc/BRIEF.md
# Chained Configuration Symbol Loader

This block sets up one pixel-processing module in a row of identical modules, using a single serial stream of 8-bit configuration symbols. The first loader in the row takes the stream straight from non-volatile storage. Each later loader takes its stream from the loader in front of it. So only one loader ever reads the storage, and the configuration path is a chain, not a shared bus.

After reset the loader is in its load phase. It accepts symbols on every valid cycle and stores each one, in arrival order, into a register file. Each entry of that file drives one configurable field of the module: a function selector, a constant or the border value.

Once its fixed-length segment is full, the loader raises its configured flag. From then on it acts as a one-register-stage forwarder with valid/ready flow control toward the next loader. While the flag is low, it also holds the module's pixel stream invalid, so no unit sees pixel data before its selector has arrived.

Top module: `cfg_chain_loader`

## Requirements
- R1: While reset is high, and in the first cycle after it, `configured`, `cfg_out_valid` and `pix_out_valid` are 0 and every bit of `unit_cfg` is 0.
- R2: The first NUM_FIELDS (default 6) symbols accepted after reset are stored in order. The k-th accepted symbol (k counted from 0) appears on `unit_cfg[k*8 +: 8]` one clock edge after it is accepted.
- R3: While `configured` is 0, `cfg_in_ready` is 1 whatever `cfg_out_ready` is, and `cfg_out_valid` stays 0. No symbol of the loader's own segment is passed downstream.
- R4: `configured` rises at the clock edge that accepts the NUM_FIELDS-th symbol and stays 1 until reset.
- R5: Once `configured` is 1, every symbol accepted on the input shows up on `cfg_out_data` with `cfg_out_valid` high one clock edge after acceptance, in arrival order and unchanged.
- R6: While `cfg_out_valid` is 1 and `cfg_out_ready` is 0, `cfg_out_data` and `cfg_out_valid` hold, and once configured `cfg_in_ready` is 0. No symbol is dropped or duplicated.
- R7: Once `configured` is 1, `unit_cfg` no longer changes. Forwarded symbols do not touch it.
- R8: `pix_out_valid` equals `pix_in_valid AND configured` from the previous cycle, and `pix_out_data` is `pix_in_data` delayed by one cycle. So pixel valid is 0 until the loader is configured.
- R9: A cycle with `cfg_in_valid` at 0 stores nothing and does not advance the store position, whatever value is on `cfg_in_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_in_data | input | SYM_W | Incoming configuration symbol |
| cfg_in_valid | input | 1 | Incoming symbol valid |
| cfg_in_ready | output | 1 | Loader can accept a symbol |
| cfg_out_data | output | SYM_W | Symbol passed to the next loader |
| cfg_out_valid | output | 1 | Passed symbol valid |
| cfg_out_ready | input | 1 | Next loader can accept |
| unit_cfg | output | NUM_FIELDS*SYM_W | Stored fields, field k at bits k*SYM_W and up |
| configured | output | 1 | Own segment fully loaded |
| pix_in_data | input | PIX_W | Pixel into the module |
| pix_in_valid | input | 1 | Pixel valid into the module |
| pix_out_data | output | PIX_W | Pixel toward the units, one cycle later |
| pix_out_valid | output | 1 | Gated pixel valid |

## Verification
The hardest situation to reach from the ports is downstream backpressure that lands exactly while the forwarding register is full and a new symbol is already waiting at the input. That is the case where a symbol could be lost or sent twice.

The stimulus gets there in three steps. First it completes the own segment. Then it lets the forwarding register drain. Then it lowers the downstream ready, pushes one symbol, and holds a second symbol at the input for several cycles before releasing the ready.

The boundary between the last stored symbol and the first forwarded one is also driven back to back, with no idle cycle between them. This checks that the symbol on the switch-over edge is stored and not forwarded.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  typedef enum logic {
    PH_LOAD = 1'b0,
    PH_PASS = 1'b1
  } phase_e;
endpackage

// File: rtl/cfgl_capture.sv
module cfgl_capture #(
  parameter int SYM_W      = 8,
  parameter int NUM_FIELDS = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        take,
  input  logic [SYM_W-1:0]            sym,
  output logic [NUM_FIELDS*SYM_W-1:0] fields,
  output logic                        done
);
  import cfgl_pkg::*;
  localparam int CNT_W = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_FIELDS - 1);

  phase_e           phase;
  logic [CNT_W-1:0] wr_idx;
  logic [SYM_W-1:0] regs [NUM_FIELDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_LOAD;
      wr_idx <= '0;
    end else if (take && phase == PH_LOAD) begin
      if (wr_idx == LAST) phase <= PH_PASS;
      else                wr_idx <= wr_idx + 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
      always_ff @(posedge clk) begin
        if (rst)
          regs[g] <= '0;
        else if (take && phase == PH_LOAD && wr_idx == CNT_W'(g))
          regs[g] <= sym;
      end
      assign fields[g*SYM_W +: SYM_W] = regs[g];
    end
  endgenerate

  assign done = (phase == PH_PASS);
endmodule

// File: rtl/cfgl_fwd_stage.sv
module cfgl_fwd_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         s_valid,
  input  logic [W-1:0] s_data,
  output logic         s_ready,
  output logic         m_valid,
  output logic [W-1:0] m_data,
  input  logic         m_ready
);
  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) m_data <= s_data;
    end
  end
endmodule

// File: rtl/cfgl_pix_gate.sv
module cfgl_pix_gate #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_valid,
  output logic [PIX_W-1:0] out_data,
  output logic             out_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid && enable;
      out_data  <= in_data;
    end
  end
endmodule

// File: rtl/cfg_chain_loader.sv
module cfg_chain_loader #(
  parameter int SYM_W      = 8,
  parameter int NUM_FIELDS = 6,
  parameter int PIX_W      = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [SYM_W-1:0]            cfg_in_data,
  input  logic                        cfg_in_valid,
  output logic                        cfg_in_ready,
  output logic [SYM_W-1:0]            cfg_out_data,
  output logic                        cfg_out_valid,
  input  logic                        cfg_out_ready,
  output logic [NUM_FIELDS*SYM_W-1:0] unit_cfg,
  output logic                        configured,
  input  logic [PIX_W-1:0]            pix_in_data,
  input  logic                        pix_in_valid,
  output logic [PIX_W-1:0]            pix_out_data,
  output logic                        pix_out_valid
);
  logic stage_ready;
  logic load_take;
  logic pass_valid;

  assign load_take    = cfg_in_valid && !configured;
  assign pass_valid   = cfg_in_valid && configured;
  assign cfg_in_ready = configured ? stage_ready : 1'b1;

  cfgl_capture #(.SYM_W(SYM_W), .NUM_FIELDS(NUM_FIELDS)) u_capture (
    .clk    (clk),
    .rst    (rst),
    .take   (load_take),
    .sym    (cfg_in_data),
    .fields (unit_cfg),
    .done   (configured)
  );

  cfgl_fwd_stage #(.W(SYM_W)) u_fwd (
    .clk     (clk),
    .rst     (rst),
    .s_valid (pass_valid),
    .s_data  (cfg_in_data),
    .s_ready (stage_ready),
    .m_valid (cfg_out_valid),
    .m_data  (cfg_out_data),
    .m_ready (cfg_out_ready)
  );

  cfgl_pix_gate #(.PIX_W(PIX_W)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .enable    (configured),
    .in_data   (pix_in_data),
    .in_valid  (pix_in_valid),
    .out_data  (pix_out_data),
    .out_valid (pix_out_valid)
  );
endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker #(
  parameter int SYM_W      = 8,
  parameter int NUM_FIELDS = 6
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        cfg_in_ready,
  input logic [SYM_W-1:0]            cfg_out_data,
  input logic                        cfg_out_valid,
  input logic                        cfg_out_ready,
  input logic [NUM_FIELDS*SYM_W-1:0] unit_cfg,
  input logic                        configured,
  input logic                        pix_out_valid
);
  AST_CFG_STICKY: assert property (@(posedge clk) disable iff (rst)
    configured |=> configured); // R4
  AST_LOAD_ALWAYS_READY: assert property (@(posedge clk) disable iff (rst)
    !configured |-> cfg_in_ready); // R3
  AST_NO_EARLY_PASS: assert property (@(posedge clk) disable iff (rst)
    !configured |-> !cfg_out_valid); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cfg_out_valid && !cfg_out_ready) |=> (cfg_out_valid && $stable(cfg_out_data))); // R6
  AST_STALL_BLOCKS_IN: assert property (@(posedge clk) disable iff (rst)
    (configured && cfg_out_valid && !cfg_out_ready) |-> !cfg_in_ready); // R6
  AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    configured |=> $stable(unit_cfg)); // R7
  AST_PIX_GATED: assert property (@(posedge clk) disable iff (rst)
    !configured |=> !pix_out_valid); // R8
endmodule

bind cfg_chain_loader cfgl_checker #(.SYM_W(SYM_W), .NUM_FIELDS(NUM_FIELDS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_in_ready  (cfg_in_ready),
  .cfg_out_data  (cfg_out_data),
  .cfg_out_valid (cfg_out_valid),
  .cfg_out_ready (cfg_out_ready),
  .unit_cfg      (unit_cfg),
  .configured    (configured),
  .pix_out_valid (pix_out_valid)
);

// File: tb/cfg_chain_loader_tb.sv
module cfg_chain_loader_tb;
  localparam int SYM_W = 8;
  localparam int NF    = 6;
  localparam int PIX_W = 8;
  localparam int NSEQ  = 10;
  localparam logic [SYM_W-1:0] SEQ [NSEQ] = '{8'h3C, 8'hA5, 8'h01, 8'hFF, 8'h00, 8'h7E,
                                              8'h11, 8'hC3, 8'h5A, 8'h80};

  logic clk = 0;
  logic rst = 1;
  logic [SYM_W-1:0] cfg_in_data = '0;
  logic cfg_in_valid = 0;
  logic cfg_in_ready;
  logic [SYM_W-1:0] cfg_out_data;
  logic cfg_out_valid;
  logic cfg_out_ready = 1;
  logic [NF*SYM_W-1:0] unit_cfg;
  logic configured;
  logic [PIX_W-1:0] pix_in_data = '0;
  logic pix_in_valid = 0;
  logic [PIX_W-1:0] pix_out_data;
  logic pix_out_valid;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  cfg_chain_loader #(.SYM_W(SYM_W), .NUM_FIELDS(NF), .PIX_W(PIX_W)) u_dut (
    .clk(clk), .rst(rst),
    .cfg_in_data(cfg_in_data), .cfg_in_valid(cfg_in_valid), .cfg_in_ready(cfg_in_ready),
    .cfg_out_data(cfg_out_data), .cfg_out_valid(cfg_out_valid), .cfg_out_ready(cfg_out_ready),
    .unit_cfg(unit_cfg), .configured(configured),
    .pix_in_data(pix_in_data), .pix_in_valid(pix_in_valid),
    .pix_out_data(pix_out_data), .pix_out_valid(pix_out_valid)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; cfg_in_valid = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  task automatic push(input logic [SYM_W-1:0] d);
    @(negedge clk);
    cfg_in_data = d; cfg_in_valid = 1;
    @(posedge clk); #1;
    cfg_in_valid = 0;
  endtask

  initial begin
    #2000000;
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: outputs during reset
    @(posedge clk); #1;
    check("R1 configured in reset", 64'(configured), 64'd0);
    check("R1 out_valid in reset", 64'(cfg_out_valid), 64'd0);
    do_reset();
    #1;
    check("R1 unit_cfg after reset", 64'(unit_cfg), 64'd0);
    check("R1 pix_out_valid after reset", 64'(pix_out_valid), 64'd0);

    // Table walk: first NF stored (R2), rest forwarded (R5), back to back
    for (int i = 0; i < NSEQ; i++) begin
      @(negedge clk);
      cfg_in_data = SEQ[i]; cfg_in_valid = 1;
      @(posedge clk); #1;
      if (i < NF) begin
        check("R2 stored field", 64'(unit_cfg[i*SYM_W +: SYM_W]), 64'(SEQ[i]));
        check("R3 own symbol not forwarded", 64'(cfg_out_valid), 64'd0);
        check("R4 configured timing", 64'(configured), (i == NF-1) ? 64'd1 : 64'd0);
      end else begin
        check("R5 forwarded valid", 64'(cfg_out_valid), 64'd1);
        check("R5 forwarded data", 64'(cfg_out_data), 64'(SEQ[i]));
      end
    end
    @(negedge clk); cfg_in_valid = 0;
    @(posedge clk); #1;
    check("R5 output idles", 64'(cfg_out_valid), 64'd0);
    for (int i = 0; i < NF; i++)
      check("R7 fields unchanged by forwarding", 64'(unit_cfg[i*SYM_W +: SYM_W]), 64'(SEQ[i]));

    // R6: backpressure with a second symbol waiting
    @(negedge clk); cfg_out_ready = 0;
    push(8'hD1);
    check("R6 first held valid", 64'(cfg_out_valid), 64'd1);
    @(negedge clk);
    cfg_in_data = 8'hE2; cfg_in_valid = 1;
    #1;
    check("R6 input stalled", 64'(cfg_in_ready), 64'd0);
    @(posedge clk); @(posedge clk); #1;
    check("R6 data held", 64'(cfg_out_data), 64'hD1);
    check("R6 valid held", 64'(cfg_out_valid), 64'd1);
    @(negedge clk); cfg_out_ready = 1;
    @(posedge clk); #1;
    cfg_in_valid = 0;
    check("R6 second after release", 64'(cfg_out_data), 64'hE2);
    check("R6 second valid", 64'(cfg_out_valid), 64'd1);
    @(posedge clk); #1;
    check("R6 no duplicate", 64'(cfg_out_valid), 64'd0);
    check("R4 stays configured", 64'(configured), 64'd1);

    // R8: pixel gating after configuration
    @(negedge clk); pix_in_data = 8'h9B; pix_in_valid = 1;
    @(posedge clk); #1;
    check("R8 pix valid passes", 64'(pix_out_valid), 64'd1);
    check("R8 pix data", 64'(pix_out_data), 64'h9B);

    // R1/R8/R9/R3: new reset, pixel blocked, idle garbage ignored
    do_reset();
    cfg_out_ready = 0;
    pix_in_valid = 1;
    @(posedge clk); #1;
    check("R8 pix blocked before config", 64'(pix_out_valid), 64'd0);
    check("R3 ready while loading under backpressure", 64'(cfg_in_ready), 64'd1);
    check("R1 configured cleared", 64'(configured), 64'd0);
    @(negedge clk); cfg_in_data = 8'h66; cfg_in_valid = 0;
    @(posedge clk); @(posedge clk); #1;
    check("R9 idle input not stored", 64'(unit_cfg[SYM_W-1:0]), 64'd0);
    for (int i = 0; i < NF; i++) begin
      push(8'(8'h20 + i));
      check("R3 no forward while loading", 64'(cfg_out_valid), 64'd0);
      if (i < NF-1) begin
        @(negedge clk); cfg_in_data = 8'hEE;
        @(posedge clk); #1;
      end
    end
    for (int i = 0; i < NF; i++)
      check("R9 order kept across gaps", 64'(unit_cfg[i*SYM_W +: SYM_W]), 64'(8'h20 + i));
    check("R4 configured after gaps", 64'(configured), 64'd1);
    @(posedge clk); #1;
    check("R8 pix enabled", 64'(pix_out_valid), 64'd1);
    pix_in_valid = 0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule